// File: doc/BRIEF.md
# Width-Selectable Subtractor with Status Flags

This block subtracts a source operand from a destination operand at one of four operand widths (8, 16, 32 or 64 bits). It returns the truncated difference and six arithmetic status flags: unsigned borrow, low-byte parity, nibble borrow, zero, sign and signed overflow. Every flag is evaluated at the selected width.

The source can optionally be treated as a short immediate. In that case its low 8 or low 32 bits are sign-extended to the operand width before the subtraction. A request is presented with `valid_i`. The result and flags appear registered one clock later with `valid_o`, and they hold their values until the next request.

Top module: `subflag_top`

## Requirements
- R1: `res_o` equals (D − S) modulo 2^W, where W is the selected width and D and S are the operands truncated to W bits. Bits of `res_o` at and above W are zero.
- R2: `cf_o` is 1 exactly when D is less than S, both taken as unsigned W-bit values.
- R3: `of_o` is 1 exactly when the sign bits (bit W−1) of D and S differ and the result's sign bit differs from D's sign bit.
- R4: `sf_o` equals bit W−1 of `res_o`.
- R5: `zf_o` is 1 exactly when all W result bits are zero. Operand bits above W have no effect on it.
- R6: `af_o` is 1 exactly when D[3:0] is less than S[3:0], taken as unsigned values.
- R7: `pf_o` is 1 exactly when `res_o[7:0]` holds an even number of ones, at every width.
- R8: `ext_i` selects the source form. 0 or 3 uses `src_i` as given. 1 sign-extends `src_i[7:0]`. 2 sign-extends `src_i[31:0]`. The extended value is then truncated to W.
- R9: `valid_o` is `valid_i` delayed by one clock. The result and flags update only in the clock after `valid_i` is high, and they hold otherwise.
- R10: `size_i` encodes W as follows: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64.
- R11: While `rst_ni` is low, `valid_o`, `res_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| size_i | input | 2 | Operand width code |
| ext_i | input | 2 | Source immediate extension code |
| dst_i | input | 64 | Destination operand (minuend) |
| src_i | input | 64 | Source operand (subtrahend) |
| valid_o | output | 1 | Result valid, one clock after request |
| res_o | output | 64 | Difference, zero above the width |
| cf_o | output | 1 | Unsigned borrow |
| pf_o | output | 1 | Even parity of the low result byte |
| af_o | output | 1 | Borrow out of bit 3 |
| zf_o | output | 1 | Result is zero |
| sf_o | output | 1 | Result sign |
| of_o | output | 1 | Signed overflow |

## Verification
The embedded assertions check four things on every cycle: the one-clock valid delay, the holding of outputs between requests, the zero upper bits of the result at the registered width, and the consistency of sign, zero and parity with the registered result. The arithmetic cannot be seen from the outputs alone. The bench scenarios therefore carry the weight for the borrow, nibble-borrow and overflow flags, for the immediate extension modes, and for the difference value itself. These scenarios mix random vectors with directed edges such as 0 − 1, the most negative value minus 1, equal operands and nonzero upper operand bits.

// File: rtl/subflag_pkg.sv
package subflag_pkg;
  localparam int unsigned OPW = 64;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} size_e;
  typedef enum logic [1:0] {EXT_NONE = 2'd0, EXT_B = 2'd1, EXT_W = 2'd2, EXT_RSV = 2'd3} ext_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } flags_t;
endpackage

// File: rtl/subflag_mask.sv
module subflag_mask #(
  parameter int unsigned OPW = subflag_pkg::OPW
) (
  input  logic [1:0]     size_i,
  output logic [OPW-1:0] mask_o,
  output logic [OPW-1:0] sbit_o
);
  localparam int unsigned NSZ = 4;

  logic [OPW-1:0] tbl [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_w
    localparam int unsigned GW = 8 << g;
    if (GW >= OPW) begin : g_full
      assign tbl[g] = '1;
    end else begin : g_part
      assign tbl[g] = {{(OPW-GW){1'b0}}, {GW{1'b1}}};
    end
  end

  assign mask_o = tbl[size_i];
  // one-hot on the sign position
  assign sbit_o = mask_o & ~(mask_o >> 1);
endmodule

// File: rtl/subflag_src.sv
module subflag_src #(
  parameter int unsigned OPW = subflag_pkg::OPW
) (
  input  logic [1:0]     ext_i,
  input  logic [OPW-1:0] src_i,
  input  logic [OPW-1:0] mask_i,
  output logic [OPW-1:0] src_o
);
  import subflag_pkg::*;

  logic [OPW-1:0] ext;

  always_comb begin
    unique case (ext_e'(ext_i))
      EXT_B:   ext = {{(OPW-8){src_i[7]}}, src_i[7:0]};
      EXT_W:   ext = {{(OPW-32){src_i[31]}}, src_i[31:0]};
      default: ext = src_i;
    endcase
  end

  assign src_o = ext & mask_i;
endmodule

// File: rtl/subflag_core.sv
module subflag_core #(
  parameter int unsigned OPW = subflag_pkg::OPW
) (
  input  logic [OPW-1:0]    a_i,
  input  logic [OPW-1:0]    b_i,
  input  logic [OPW-1:0]    mask_i,
  input  logic [OPW-1:0]    sbit_i,
  output logic [OPW-1:0]    res_o,
  output subflag_pkg::flags_t flg_o
);
  logic [OPW:0] diff;
  logic [4:0]   nib;
  logic         sa, sb, sr;

  // operands arrive masked, so bit OPW is the borrow at the selected width
  assign diff = {1'b0, a_i} - {1'b0, b_i};
  assign nib  = {1'b0, a_i[3:0]} - {1'b0, b_i[3:0]};
  assign res_o = diff[OPW-1:0] & mask_i;

  assign sa = |(a_i & sbit_i);
  assign sb = |(b_i & sbit_i);
  assign sr = |(res_o & sbit_i);

  always_comb begin
    flg_o.cf = diff[OPW];
    flg_o.pf = ~^res_o[7:0];
    flg_o.af = nib[4];
    flg_o.zf = ~|res_o;
    flg_o.sf = sr;
    flg_o.of = (sa ^ sb) & (sr ^ sa);
  end
endmodule

// File: rtl/subflag_top.sv
module subflag_top #(
  parameter int unsigned OPW = subflag_pkg::OPW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [1:0]     size_i,
  input  logic [1:0]     ext_i,
  input  logic [OPW-1:0] dst_i,
  input  logic [OPW-1:0] src_i,
  output logic           valid_o,
  output logic [OPW-1:0] res_o,
  output logic           cf_o,
  output logic           pf_o,
  output logic           af_o,
  output logic           zf_o,
  output logic           sf_o,
  output logic           of_o
);
  import subflag_pkg::*;

  logic [OPW-1:0] mask, sbit, a_m, b_m, res_d;
  flags_t         flg_d, flg_q;
  logic [1:0]     size_q;
  logic [OPW-1:0] mask_q, sbit_q;

  subflag_mask #(.OPW(OPW)) u_mask (.size_i(size_i), .mask_o(mask), .sbit_o(sbit));

  assign a_m = dst_i & mask;

  subflag_src #(.OPW(OPW)) u_src (
    .ext_i(ext_i), .src_i(src_i), .mask_i(mask), .src_o(b_m)
  );

  subflag_core #(.OPW(OPW)) u_core (
    .a_i(a_m), .b_i(b_m), .mask_i(mask), .sbit_i(sbit),
    .res_o(res_d), .flg_o(flg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      flg_q   <= '0;
      size_q  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o  <= res_d;
        flg_q  <= flg_d;
        size_q <= size_i;
      end
    end
  end

  assign cf_o = flg_q.cf;
  assign pf_o = flg_q.pf;
  assign af_o = flg_q.af;
  assign zf_o = flg_q.zf;
  assign sf_o = flg_q.sf;
  assign of_o = flg_q.of;

  // width of the held result, for checking only
  subflag_mask #(.OPW(OPW)) u_mask_q (.size_i(size_q), .mask_o(mask_q), .sbit_o(sbit_q));

  // R9
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(flg_q)));
  // R1
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o & ~mask_q) == '0);
  // R4
  sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sf_o == |(res_o & sbit_q)));
  // R5
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zf_o == (res_o == '0)));
  // R7
  parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pf_o == ($countones(res_o[7:0]) % 2 == 0)));
endmodule

// File: tb/subflag_top_test.sv
module subflag_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [1:0]  ext_i = '0;
  logic [63:0] dst_i = '0;
  logic [63:0] src_i = '0;
  logic        valid_o;
  logic [63:0] res_o;
  logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  subflag_top uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .size_i(size_i), .ext_i(ext_i),
    .dst_i(dst_i), .src_i(src_i), .valid_o(valid_o), .res_o(res_o),
    .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] wmask(input logic [1:0] s);
    return (s == 2'd3) ? '1 : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  task automatic run(input logic [1:0] s, input logic [1:0] e, input logic [63:0] d, input logic [63:0] x);
    logic [63:0] m, sx, a, b, r;
    int tb;
    bit ecf, eof, eaf, epf, ezf, esf;
    m  = wmask(s);
    sx = (e == 2'd1) ? {{56{x[7]}}, x[7:0]} : (e == 2'd2) ? {{32{x[31]}}, x[31:0]} : x;
    a  = d & m;
    b  = sx & m;
    r  = (a - b) & m;
    tb = (8 << s) - 1;
    ecf = a < b;
    esf = r[tb];
    eof = (a[tb] != b[tb]) && (r[tb] != a[tb]);
    eaf = a[3:0] < b[3:0];
    epf = ~^r[7:0];
    ezf = (r == 0);
    @(negedge clk);
    valid_i = 1'b1; size_i = s; ext_i = e; dst_i = d; src_i = x;
    @(negedge clk);
    valid_i = 1'b0;
    dst_i = ~d; src_i = d;
    chk(valid_o == 1'b1, "R9 valid", 64'(valid_o), 64'd1);
    chk(res_o == r, (e != 0) ? "R1/R8 result" : "R1/R10 result", res_o, r);
    chk(cf_o == ecf, "R2 cf", 64'(cf_o), 64'(ecf));
    chk(of_o == eof, "R3 of", 64'(of_o), 64'(eof));
    chk(sf_o == esf, "R4 sf", 64'(sf_o), 64'(esf));
    chk(zf_o == ezf, "R5 zf", 64'(zf_o), 64'(ezf));
    chk(af_o == eaf, "R6 af", 64'(af_o), 64'(eaf));
    chk(pf_o == epf, "R7 pf", 64'(pf_o), 64'(epf));
    // R9: an idle cycle leaves the outputs alone
    @(negedge clk);
    chk(valid_o == 1'b0, "R9 idle valid", 64'(valid_o), 64'd0);
    chk(res_o == r, "R9 hold", res_o, r);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R11
    chk(valid_o == 0 && res_o == 0, "R11 reset out", res_o, 64'd0);
    chk({cf_o, pf_o, af_o, zf_o, sf_o, of_o} == 6'd0, "R11 reset flags",
        64'({cf_o, pf_o, af_o, zf_o, sf_o, of_o}), 64'd0);
    rst_n = 1'b1;
    // R10 directed: 0x100 - 1 at byte width sees only the low byte
    run(2'd0, 2'd0, 64'h100, 64'h1);
    run(2'd0, 2'd0, 64'h80, 64'h1);             // R3 signed overflow byte
    run(2'd1, 2'd0, 64'hFFFF_0000_0000_8000, 64'h1); // R5 upper bits ignored
    run(2'd2, 2'd0, 64'h5, 64'h5);              // zero result
    run(2'd3, 2'd0, 64'h8000_0000_0000_0000, 64'h1);
    run(2'd3, 2'd0, 64'h0, 64'h1);              // R2 full-width borrow
    run(2'd3, 2'd1, 64'h10, 64'hFF);            // R8 byte immediate -1
    run(2'd3, 2'd2, 64'h0, 64'h8000_0000);      // R8 32-bit immediate negative
    run(2'd1, 2'd1, 64'h0, 64'h7F);
    run(2'd2, 2'd3, 64'h1_0000_0010, 64'h11);   // R6 nibble borrow
    for (int i = 0; i < 400; i++) begin
      run(2'($urandom), 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule